// File: doc/BRIEF.md
# Self-Checking Configurable Function Cell

This block is a single arithmetic and logic cell whose operation is picked by a wide configuration word. Four 16-bit two's complement operands are captured into input registers that are each held three times over. The registers are read through a bitwise majority vote and rewritten with the voted value on every clock, so a bit upset in one copy is outvoted at once and then cleaned out.

The operation itself is computed by two identical function units. The primary unit drives the result register. A comparator watches both units on every cycle, and any difference between them raises a fault flag that stays set until reset. This marks the cell as permanently damaged, so that circuitry outside the block can retire it.

A fault-injection port lets a test flip chosen bits in one stored copy of one operand, or hold bit 0 of the secondary unit's output inverted. Once the first operand set has been captured, the result register is refreshed on every cycle from the stored operands.

Top module: `selfcheck_cell`

## Requirements
- R1: While reset is asserted, and after reset is released, `result` is 0, `resultValid` is 0 and `permFault` is 0 until the first load.
- R2: When `inValid` is high at a rising edge, the four operands and the opcode are stored. `result` shows the outcome at the next edge and is then refreshed every cycle. `resultValid` rises with that first result and stays high until reset.
- R3: The opcode is `cfgCode[3:0]`, and all other code bits are ignored. The encodings are: 0 = A AND B, 1 = A OR B, 2 = NOT A, 3 = A+B, 4 = A-B, 5 = A*B, 6 = compare, 7 = select, 8 = delay.
- R4: The opcodes 9 to 15 give a result of 0.
- R5: An injection (`injEn`=1, with `injOperand` 0..3 choosing A..D, `injCopy` 0..2 choosing the copy, and `injMask` giving the bits to flip) corrupts only one copy. This causes no wrong result, including when three successive loads each corrupt a different operand.
- R6: All three copies of every operand are rewritten with the voted value on every cycle. Corrupting copy 0 and then the same bit of copy 1 on the next cycle therefore still gives a correct result.
- R7: Any difference between the two function units sets `permFault` at the next edge. Holding `injStuck` high inverts bit 0 of the secondary unit only, so `result` stays correct.
- R8: Once set, `permFault` stays high until reset, even after the fault goes away.
- R9: Opcode 8 returns the voted operand A as it was stored one cycle earlier. Its history register reads 0 after reset.
- R10: Multiplication keeps the low 16 bits of the product. Compare returns 1 when A > B as signed values and 0 otherwise. Select returns C when bit 0 of D is 1 and B otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Load operands and opcode |
| opA | input | 16 | Operand A |
| opB | input | 16 | Operand B |
| opC | input | 16 | Operand C |
| opD | input | 16 | Operand D |
| cfgCode | input | 66 | Configuration word; low 4 bits are the opcode |
| injEn | input | 1 | Apply a transient bit-flip this cycle |
| injOperand | input | 2 | Operand to corrupt (0..3 = A..D) |
| injCopy | input | 2 | Stored copy to corrupt (0..2; 3 = none) |
| injMask | input | 16 | Bits to flip |
| injStuck | input | 1 | Invert bit 0 of the secondary function unit |
| result | output | 16 | Registered result of the primary unit |
| resultValid | output | 1 | Result reflects a loaded operand set |
| permFault | output | 1 | Sticky mismatch flag between the function units |

## Verification
The bench builds the cell with its default parameters: 16-bit operands, four operands and a 66-bit configuration word. With these values the sign bit sits at bit 15, so the carry into it (0x7FFF+1), the truncation of the product to its low half, and a signed compare against an all-ones operand are all within reach. The upper 62 configuration bits are held at a busy nonzero pattern, which shows that only the low opcode field steers the cell.

// File: rtl/selfcheck_cell_pkg.sv
`timescale 1ns/1ps
package selfcheck_cell_pkg;

  localparam int OPC_W        = 4;
  localparam int NUM_OPERANDS = 4;
  localparam int NUM_COPIES   = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_NOT = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_MUL = 4'd5,
    OP_CMP = 4'd6,
    OP_SEL = 4'd7,
    OP_DLY = 4'd8
  } cellOp_e;

  typedef struct packed {
    logic loadOps;
    logic capture;
  } cellStrobe_t;

endpackage

// File: rtl/tmr_operand_reg.sv
`timescale 1ns/1ps
module tmr_operand_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dIn,
  input  logic         injHit,
  input  logic [1:0]   injCopy,
  input  logic [W-1:0] injMask,
  output logic [W-1:0] voted
);
  import selfcheck_cell_pkg::*;

  logic [W-1:0] copyQ [NUM_COPIES];
  logic [W-1:0] base;

  assign voted = (copyQ[0] & copyQ[1]) | (copyQ[0] & copyQ[2]) | (copyQ[1] & copyQ[2]);
  assign base  = load ? dIn : voted;

  for (genvar i = 0; i < NUM_COPIES; i++) begin : gCopy
    logic hit;
    assign hit = injHit && (injCopy == 2'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) copyQ[i] <= '0;
      else        copyQ[i] <= base ^ (hit ? injMask : '0);
    end
  end

  AST_SCRUB_ALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    !injHit |=> (copyQ[0] == copyQ[1]) && (copyQ[1] == copyQ[2])); // R6

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !injHit) |=> (voted == $past(dIn))); // R2

endmodule

// File: rtl/func_unit.sv
`timescale 1ns/1ps
module func_unit #(
  parameter int W = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   capture,
  input  logic [selfcheck_cell_pkg::OPC_W-1:0]   opcode,
  input  logic [W-1:0]                           a,
  input  logic [W-1:0]                           b,
  input  logic [W-1:0]                           c,
  input  logic [W-1:0]                           d,
  input  logic                                   stuck,
  output logic [W-1:0]                           res
);
  import selfcheck_cell_pkg::*;

  logic [W-1:0] dlyQ;
  logic [W-1:0] raw;
  logic [W-1:0] prod;
  logic         unusedDHigh;

  assign unusedDHigh = ^d[W-1:1];
  assign prod = a * b;

  always_ff @(posedge clk) begin
    if (!rst_n)       dlyQ <= '0;
    else if (capture) dlyQ <= a;
  end

  always_comb begin
    case (opcode)
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_NOT:  raw = ~a;
      OP_ADD:  raw = a + b;
      OP_SUB:  raw = a - b;
      OP_MUL:  raw = prod;
      OP_CMP:  raw = {{(W-1){1'b0}}, ($signed(a) > $signed(b))};
      OP_SEL:  raw = d[0] ? c : b;
      OP_DLY:  raw = dlyQ;
      default: raw = '0;
    endcase
  end

  assign res = raw ^ {{(W-1){1'b0}}, stuck};

  AST_DELAY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (dlyQ == $past(a))); // R9

endmodule

// File: rtl/cell_datapath.sv
`timescale 1ns/1ps
module cell_datapath #(
  parameter int DATA_W = 16
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  selfcheck_cell_pkg::cellStrobe_t               strobe,
  input  logic [selfcheck_cell_pkg::NUM_OPERANDS*DATA_W-1:0] opsFlat,
  input  logic [selfcheck_cell_pkg::OPC_W-1:0]          opcodeIn,
  input  logic                                          injEn,
  input  logic [1:0]                                    injOperand,
  input  logic [1:0]                                    injCopy,
  input  logic [DATA_W-1:0]                             injMask,
  input  logic                                          injStuck,
  output logic [DATA_W-1:0]                             resultQ,
  output logic                                          mismatch
);
  import selfcheck_cell_pkg::*;

  localparam int NUM_UNITS = 2;

  logic [DATA_W-1:0] opV     [NUM_OPERANDS];
  logic [DATA_W-1:0] unitRes [NUM_UNITS];
  logic [OPC_W-1:0]  opcodeQ;

  always_ff @(posedge clk) begin
    if (!rst_n)              opcodeQ <= '0;
    else if (strobe.loadOps) opcodeQ <= opcodeIn;
  end

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : gOperand
    logic hit;
    assign hit = injEn && (injOperand == 2'(g));
    tmr_operand_reg #(.W(DATA_W)) uReg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (strobe.loadOps),
      .dIn     (opsFlat[g*DATA_W +: DATA_W]),
      .injHit  (hit),
      .injCopy (injCopy),
      .injMask (injMask),
      .voted   (opV[g])
    );
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    logic stuckHere;
    assign stuckHere = (u == NUM_UNITS-1) ? injStuck : 1'b0;
    func_unit #(.W(DATA_W)) uFu (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (strobe.capture),
      .opcode  (opcodeQ),
      .a       (opV[0]),
      .b       (opV[1]),
      .c       (opV[2]),
      .d       (opV[3]),
      .stuck   (stuckHere),
      .res     (unitRes[u])
    );
  end

  assign mismatch = (unitRes[0] != unitRes[1]);

  always_ff @(posedge clk) begin
    if (!rst_n)              resultQ <= '0;
    else if (strobe.capture) resultQ <= unitRes[0];
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && (opcodeQ > OPC_W'(OP_DLY))) |=> (resultQ == '0)); // R4

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(resultQ)); // R2

endmodule

// File: rtl/cell_control.sv
`timescale 1ns/1ps
module cell_control (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inValid,
  input  logic                           mismatch,
  output selfcheck_cell_pkg::cellStrobe_t strobe,
  output logic                           resultValid,
  output logic                           permFault
);
  logic loadedQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loadedQ     <= 1'b0;
      resultValid <= 1'b0;
      permFault   <= 1'b0;
    end else begin
      if (inValid) loadedQ <= 1'b1;
      resultValid <= loadedQ;
      if (mismatch) permFault <= 1'b1;
    end
  end

  assign strobe.loadOps = inValid;
  assign strobe.capture = loadedQ;

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> resultValid); // R2

  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> permFault); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    permFault |=> permFault); // R8

endmodule

// File: rtl/selfcheck_cell.sv
`timescale 1ns/1ps
module selfcheck_cell #(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [DATA_W-1:0] opD,
  input  logic [CFG_W-1:0]  cfgCode,
  input  logic              injEn,
  input  logic [1:0]        injOperand,
  input  logic [1:0]        injCopy,
  input  logic [DATA_W-1:0] injMask,
  input  logic              injStuck,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              permFault
);
  import selfcheck_cell_pkg::*;

  cellStrobe_t strobe;
  logic        mismatch;
  logic        unusedCfgBits;

  assign unusedCfgBits = ^cfgCode[CFG_W-1:OPC_W];

  cell_control uCtl (
    .clk         (clk),
    .rst_n       (rst_n),
    .inValid     (inValid),
    .mismatch    (mismatch),
    .strobe      (strobe),
    .resultValid (resultValid),
    .permFault   (permFault)
  );

  cell_datapath #(.DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .opsFlat    ({opD, opC, opB, opA}),
    .opcodeIn   (cfgCode[OPC_W-1:0]),
    .injEn      (injEn),
    .injOperand (injOperand),
    .injCopy    (injCopy),
    .injMask    (injMask),
    .injStuck   (injStuck),
    .resultQ    (result),
    .mismatch   (mismatch)
  );

endmodule

// File: tb/sim_selfcheck_cell.sv
`timescale 1ns/1ps
module sim_selfcheck_cell;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0, opC = '0, opD = '0;
  logic [65:0] cfgCode = '0;
  logic        injEn = 1'b0;
  logic [1:0]  injOperand = '0;
  logic [1:0]  injCopy = 2'd3;
  logic [15:0] injMask = '0;
  logic        injStuck = 1'b0;
  logic [15:0] result;
  logic        resultValid;
  logic        permFault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [61:0] CFG_HIGH = 62'h2A5A_C3F0_1E96_7D4B;

  // a, b, c, d, opcode, expected
  localparam int NVEC = 14;
  localparam logic [83:0] VEC [NVEC] = '{
    {16'h0F0F, 16'h00FF, 16'h0000, 16'h0000, 4'd0, 16'h000F},
    {16'h0F00, 16'h00F0, 16'h0000, 16'h0000, 4'd1, 16'h0FF0},
    {16'h1234, 16'h0000, 16'h0000, 16'h0000, 4'd2, 16'hEDCB},
    {16'h7FFF, 16'h0001, 16'h0000, 16'h0000, 4'd3, 16'h8000},
    {16'h0003, 16'h0005, 16'h0000, 16'h0000, 4'd4, 16'hFFFE},
    {16'h0100, 16'h0100, 16'h0000, 16'h0000, 4'd5, 16'h0000},
    {16'hFFFF, 16'h0003, 16'h0000, 16'h0000, 4'd5, 16'hFFFD},
    {16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 4'd6, 16'h0000},
    {16'h0002, 16'h0001, 16'h0000, 16'h0000, 4'd6, 16'h0001},
    {16'h0000, 16'hAAAA, 16'h5555, 16'h0001, 4'd7, 16'h5555},
    {16'h1111, 16'hAAAA, 16'h5555, 16'h0000, 4'd7, 16'hAAAA},
    {16'h4444, 16'h0000, 16'h0000, 16'h0000, 4'd8, 16'h1111},
    {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 4'd9, 16'h0000},
    {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 4'd15, 16'h0000}
  };

  always #4 clk = ~clk;

  selfcheck_cell u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD), .cfgCode(cfgCode),
    .injEn(injEn), .injOperand(injOperand), .injCopy(injCopy),
    .injMask(injMask), .injStuck(injStuck),
    .result(result), .resultValid(resultValid), .permFault(permFault)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the result edge.
  task automatic loadOps(input logic [15:0] a, b, c, d, input logic [3:0] opc,
                         input logic ie, input logic [1:0] iop, icp,
                         input logic [15:0] imask);
    opA = a; opB = b; opC = c; opD = d;
    cfgCode = {CFG_HIGH, opc};
    inValid = 1'b1;
    injEn = ie; injOperand = iop; injCopy = icp; injMask = imask;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; injEn = 1'b0; injCopy = 2'd3; injMask = '0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 result in reset", result, 16'h0);
    chk("R1 valid in reset", {15'b0, resultValid}, 16'h0);
    chk("R1 fault in reset", {15'b0, permFault}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid before load", {15'b0, resultValid}, 16'h0);

    // R3 R4 R9 R10: table walk
    for (int i = 0; i < NVEC; i++) begin
      loadOps(VEC[i][83:68], VEC[i][67:52], VEC[i][51:36], VEC[i][35:20],
              VEC[i][19:16], 1'b0, 2'd0, 2'd3, 16'h0);
      chk($sformatf("R3/R4/R10 vector %0d", i), result, VEC[i][15:0]);
      if (i == 11) begin
        @(posedge clk); @(negedge clk);
        chk("R9 delay shows newer A one cycle later", result, 16'h4444);
      end
    end

    // R2: valid and result hold while idle
    repeat (3) @(negedge clk);
    chk("R2 valid stays high", {15'b0, resultValid}, 16'h1);
    chk("R2 result refreshed from stored operands", result, 16'h0);

    // R5: three loads, each corrupting a different operand
    loadOps(16'h0010, 16'h0020, 16'h0, 16'h0, 4'd3, 1'b1, 2'd0, 2'd0, 16'hFFFF);
    chk("R5 flip in A copy0", result, 16'h0030);
    loadOps(16'h0000, 16'h0001, 16'h0002, 16'h0000, 4'd7, 1'b1, 2'd3, 2'd1, 16'h0001);
    chk("R5 flip in D copy1", result, 16'h0001);
    loadOps(16'h0100, 16'h0001, 16'h0, 16'h0, 4'd4, 1'b1, 2'd1, 2'd2, 16'h8000);
    chk("R5 flip in B copy2", result, 16'h00FF);

    // R6: scrub between successive flips of the same bit in two copies
    loadOps(16'h0001, 16'h0002, 16'h0, 16'h0, 4'd3, 1'b0, 2'd0, 2'd3, 16'h0);
    injEn = 1'b1; injOperand = 2'd0; injCopy = 2'd0; injMask = 16'h0100;
    @(posedge clk); @(negedge clk);
    injCopy = 2'd1;
    @(posedge clk); @(negedge clk);
    injEn = 1'b0; injCopy = 2'd3; injMask = '0;
    @(posedge clk); @(negedge clk);
    chk("R6 scrub masks second flip", result, 16'h0003);
    @(posedge clk); @(negedge clk);
    chk("R6 result stays clean", result, 16'h0003);

    // R7: stuck bit in secondary unit
    chk("R7 no fault before injection", {15'b0, permFault}, 16'h0);
    injStuck = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 fault flagged", {15'b0, permFault}, 16'h1);
    chk("R7 primary result unaffected", result, 16'h0003);

    // R8: sticky after fault removed
    injStuck = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 fault remains set", {15'b0, permFault}, 16'h1);

    // R1 R8: reset clears everything
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 reset clears fault", {15'b0, permFault}, 16'h0);
    chk("R1 result cleared", result, 16'h0);
    chk("R1 valid cleared", {15'b0, resultValid}, 16'h0);

    // R9: history reads zero after reset
    loadOps(16'h7777, 16'h0, 16'h0, 16'h0, 4'd8, 1'b0, 2'd0, 2'd3, 16'h0);
    chk("R9 delay history zero after reset", result, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule